// File: doc/BRIEF.md
# Charge-Pump Phase-Frequency Comparator with Pump Override

This block sits in the digital part of a frequency synthesizer. It builds its own 100 kHz comparison reference by counting 76 cycles of the 7.6 MHz crystal clock that also clocks the block. It then compares that reference against the rising edges of the divided-down oscillator signal. Whichever of the two events arrives first opens a pump request: an up request when the reference leads, and a down request when the feedback leads. The request closes when the other event arrives. When the two events land in the same clock cycle, the detector stays in its dead state and raises no request.

A 2-bit mode field sits between the detector and the pump pins. It passes the detector through, holds the pump permanently sinking or permanently sourcing, or releases the pump so that nothing drives it. In every mode other than tracking, the detector state is held cleared, so that tracking resumes from a clean start.

A lock indicator watches each reference period. It declares lock after sixteen consecutive periods in which no pump request lasted four clocks or longer. The first period that breaks this rule drops the indicator.

Detector states: `DET_IDLE` (dead state, no request), `DET_UP` (reference seen, waiting for feedback), `DET_DN` (feedback seen, waiting for reference). Detector transitions:
- `DET_IDLE` to `DET_UP` on a reference event without a feedback event.
- `DET_IDLE` to `DET_DN` on a feedback event without a reference event.
- `DET_UP` to `DET_IDLE` on a feedback event.
- `DET_DN` to `DET_IDLE` on a reference event.
- Any state to `DET_IDLE` while the mode is not tracking.

Lock states: `LK_SEEK` (counting good periods) and `LK_HELD` (locked). Lock transitions:
- `LK_SEEK` to `LK_HELD` when a period ends good and sixteen good periods have been counted.
- `LK_HELD` to `LK_SEEK` when a period ends bad.
- Any state to `LK_SEEK` while the mode is not tracking.

Top module: `pump_phase_comparator`

## Requirements
- R1: A reference event occurs in every 76th clock cycle. The first one occurs in the cycle after the 75th rising edge that follows reset release. With fb_in held low in tracking mode, pump_up therefore rises after the 76th edge and, once cleared, rises again after the 152nd edge.
- R2: After reset, and in tracking mode (mode_sel = 2'b00), pump_drive_en is 1. At reset, pump_up, pump_dn and lock_ok are 0.
- R3: fb_in passes through two synchronizer flip-flops. A rise of fb_in first sampled at edge X becomes a feedback event in the cycle after edge X+1. If the reference event precedes the feedback event, pump_up is high from the edge after the reference event up to the edge that follows the feedback event, and pump_dn stays low.
- R4: If the feedback event precedes the reference event, pump_dn is high from the edge after the feedback event up to the edge that follows the reference event, and pump_up stays low.
- R5: pump_up and pump_dn are never both high in tracking mode. A reference event and a feedback event in the same cycle produce no request.
- R6: mode_sel = 2'b10 (bit 1 set, bit 0 clear) forces pump_dn = 1, pump_up = 0 and pump_drive_en = 1 in the same cycle.
- R7: mode_sel = 2'b01 (bit 0 set, bit 1 clear) forces pump_up = 1, pump_dn = 0 and pump_drive_en = 1 in the same cycle.
- R8: mode_sel = 2'b11 sets pump_drive_en = 0, pump_up = 0 and pump_dn = 0 in the same cycle.
- R9: Any edge that sees a non-tracking mode clears the detector. On the return to tracking, pump_up and pump_dn are both 0 until the next reference or feedback event.
- R10: lock_ok rises at the edge that ends the 16th consecutive good reference period. A period is good when no pump_up run and no pump_dn run inside it lasted 4 or more clocks. A period ends at the edge that follows a reference event. A pump_dn run ended by that event belongs to the ending period. A pump_up run started by that event belongs to the next period.
- R11: lock_ok falls at the edge that ends the first bad period. Lock is then re-acquired only after 16 new consecutive good periods.
- R12: While mode_sel is not tracking, lock_ok is cleared at the next edge and the good-period count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 7.6 MHz crystal clock, also the detector sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_in | input | 1 | Divided feedback signal from the programmable divider |
| mode_sel | input | 2 | Pump mode: 00 track, 01 force high, 10 force low, 11 release |
| pump_up | output | 1 | Request to source charge (raise control voltage) |
| pump_dn | output | 1 | Request to sink charge (lower control voltage) |
| pump_drive_en | output | 1 | Pump output enable; 0 puts the pump in high impedance |
| lock_ok | output | 1 | Lock indicator |

## Verification
The hardest situations to reach from the ports are a feedback event that lands in exactly the same cycle as the internally generated reference event, and request runs that sit exactly at the three-versus-four clock boundary on either side of a period end. Neither the reference phase nor the synchronizer delay is visible at the ports. The stimulus therefore counts edges from reset release and places each fb_in rise at a signed offset from the known reference cycle. That offset sets the run length and direction exactly, and an offset of zero produces a coincident event. Long sequences of such periods, broken by deliberate four- and five-clock runs and by a short override window, then walk the lock indicator through acquisition, loss and restart.

// File: rtl/pfd_pkg.sv
`timescale 1ns/1ps
package pfd_pkg;

    // mode_sel[0] is the "high" select bit, mode_sel[1] the "low" select bit
    typedef enum logic [1:0] {
        MODE_TRACK     = 2'b00,
        MODE_PUMP_HIGH = 2'b01,
        MODE_PUMP_LOW  = 2'b10,
        MODE_FLOAT     = 2'b11
    } pump_mode_t;

    typedef enum logic [1:0] {
        DET_IDLE = 2'b00,
        DET_UP   = 2'b01,
        DET_DN   = 2'b10
    } det_state_t;

    typedef enum logic {
        LK_SEEK = 1'b0,
        LK_HELD = 1'b1
    } lock_state_t;

endpackage

// File: rtl/pfd_ref_divider.sv
`timescale 1ns/1ps
// Free-running divider: one-cycle reference event every REF_DIV clocks.
module pfd_ref_divider #(
    parameter int REF_DIV = 76
) (
    input  logic clk,
    input  logic rst_n,
    output logic ref_tick
);
    localparam int CW = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(REF_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign ref_tick = (cnt_q == LAST);

endmodule

// File: rtl/pfd_fb_edge.sv
`timescale 1ns/1ps
// Resynchronizes the feedback input and marks each rising edge for one cycle.
module pfd_fb_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fb_in,
    output logic fb_tick
);
    logic [STAGES:0] shr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shr_q <= '0;
        end else begin
            shr_q <= {shr_q[STAGES-1:0], fb_in};
        end
    end

    // newest settled sample high, one older sample low
    assign fb_tick = shr_q[STAGES-1] & ~shr_q[STAGES];

endmodule

// File: rtl/pfd_detect_fsm.sv
`timescale 1ns/1ps
// Three-state phase-frequency detector; DET_IDLE is the dead state.
module pfd_detect_fsm
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic fb_tick,
    input  logic hold,
    output logic up_req,
    output logic dn_req
);
    det_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DET_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (hold) begin
            state_d = DET_IDLE;
        end else begin
            unique case (state_q)
                DET_IDLE: begin
                    if (ref_tick && !fb_tick) begin
                        state_d = DET_UP;
                    end else if (fb_tick && !ref_tick) begin
                        state_d = DET_DN;
                    end
                end
                DET_UP: begin
                    if (fb_tick) begin
                        state_d = DET_IDLE;
                    end
                end
                DET_DN: begin
                    if (ref_tick) begin
                        state_d = DET_IDLE;
                    end
                end
                default: state_d = DET_IDLE;
            endcase
        end
    end

    always_comb begin
        up_req = (state_q == DET_UP);
        dn_req = (state_q == DET_DN);
    end

endmodule

// File: rtl/pfd_lock_monitor.sv
`timescale 1ns/1ps
// Judges each reference period by the longest pump request run inside it.
module pfd_lock_monitor
    import pfd_pkg::*;
#(
    parameter int PULSE_LIMIT  = 4,
    parameter int LOCK_PERIODS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic up_req,
    input  logic dn_req,
    input  logic hold,
    output logic lock_ok
);
    localparam int WW = $clog2(PULSE_LIMIT + 1);
    localparam int GW = $clog2(LOCK_PERIODS + 1);
    localparam logic [WW-1:0] RUN_SAT  = WW'(PULSE_LIMIT);
    localparam logic [WW-1:0] RUN_LAST = WW'(PULSE_LIMIT - 1);
    localparam logic [GW-1:0] GOOD_MAX = GW'(LOCK_PERIODS);

    lock_state_t   lk_q, lk_d;
    logic [WW-1:0] run_q;
    logic          viol_q;
    logic [GW-1:0] good_q, good_d, good_inc;
    logic          active, long_now, period_bad;

    assign active     = up_req | dn_req;
    assign long_now   = active && (run_q >= RUN_LAST);
    assign period_bad = viol_q | long_now;
    assign good_inc   = (good_q == GOOD_MAX) ? good_q : good_q + 1'b1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_q <= LK_SEEK;
        end else if (hold) begin
            lk_q <= LK_SEEK;
        end else if (ref_tick) begin
            lk_q <= lk_d;
        end
    end

    // run length, violation flag and good-period count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= '0;
            viol_q <= 1'b0;
            good_q <= '0;
        end else if (hold) begin
            run_q  <= '0;
            viol_q <= 1'b0;
            good_q <= '0;
        end else begin
            if (!active) begin
                run_q <= '0;
            end else if (run_q != RUN_SAT) begin
                run_q <= run_q + 1'b1;
            end
            if (ref_tick) begin
                viol_q <= 1'b0;
                good_q <= good_d;
            end else begin
                viol_q <= period_bad;
            end
        end
    end

    always_comb begin
        lk_d   = lk_q;
        good_d = good_q;
        unique case (lk_q)
            LK_SEEK: begin
                if (period_bad) begin
                    good_d = '0;
                end else begin
                    good_d = good_inc;
                    if (good_inc >= GOOD_MAX) begin
                        lk_d = LK_HELD;
                    end
                end
            end
            LK_HELD: begin
                if (period_bad) begin
                    good_d = '0;
                    lk_d   = LK_SEEK;
                end else begin
                    good_d = good_inc;
                end
            end
        endcase
    end

    always_comb begin
        lock_ok = (lk_q == LK_HELD);
    end

endmodule

// File: rtl/pump_phase_comparator.sv
`timescale 1ns/1ps
module pump_phase_comparator
    import pfd_pkg::*;
#(
    parameter int REF_DIV      = 76,
    parameter int SYNC_STAGES  = 2,
    parameter int PULSE_LIMIT  = 4,
    parameter int LOCK_PERIODS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fb_in,
    input  logic [1:0] mode_sel,
    output logic       pump_up,
    output logic       pump_dn,
    output logic       pump_drive_en,
    output logic       lock_ok
);
    pump_mode_t mode;
    logic       ref_tick;
    logic       fb_tick;
    logic       hold;
    logic       up_req;
    logic       dn_req;

    assign mode = pump_mode_t'(mode_sel);
    assign hold = (mode != MODE_TRACK);

    pfd_ref_divider #(.REF_DIV(REF_DIV)) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick)
    );

    pfd_fb_edge #(.STAGES(SYNC_STAGES)) u_fb (
        .clk     (clk),
        .rst_n   (rst_n),
        .fb_in   (fb_in),
        .fb_tick (fb_tick)
    );

    pfd_detect_fsm u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .fb_tick  (fb_tick),
        .hold     (hold),
        .up_req   (up_req),
        .dn_req   (dn_req)
    );

    pfd_lock_monitor #(
        .PULSE_LIMIT  (PULSE_LIMIT),
        .LOCK_PERIODS (LOCK_PERIODS)
    ) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .up_req   (up_req),
        .dn_req   (dn_req),
        .hold     (hold),
        .lock_ok  (lock_ok)
    );

    // output process: mode override in front of the pump
    always_comb begin
        pump_up       = 1'b0;
        pump_dn       = 1'b0;
        pump_drive_en = 1'b1;
        unique case (mode)
            MODE_TRACK: begin
                pump_up = up_req;
                pump_dn = dn_req;
            end
            MODE_PUMP_HIGH: begin
                pump_up = 1'b1;
            end
            MODE_PUMP_LOW: begin
                pump_dn = 1'b1;
            end
            MODE_FLOAT: begin
                pump_drive_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pfd_checker.sv
`timescale 1ns/1ps
module pfd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_sel,
    input logic       pump_up,
    input logic       pump_dn,
    input logic       pump_drive_en,
    input logic       lock_ok,
    input logic       ref_tick,
    input logic       fb_tick
);
    assert_never_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b00) |-> !(pump_up && pump_dn));

    assert_force_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b10) |-> (pump_dn && !pump_up && pump_drive_en));

    assert_force_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b01) |-> (pump_up && !pump_dn && pump_drive_en));

    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b11) |-> (!pump_drive_en && !pump_up && !pump_dn));

    assert_clean_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b00 && $past(mode_sel) != 2'b00) |-> (!pump_up && !pump_dn));

    assert_up_after_ref_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b00 && $past(mode_sel) == 2'b00 && $rose(pump_up)) |-> $past(ref_tick));

    assert_dn_after_fb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b00 && $past(mode_sel) == 2'b00 && $rose(pump_dn)) |-> $past(fb_tick));

    assert_lock_on_period_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_ok) |-> $past(ref_tick));

    assert_lock_cleared_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel != 2'b00) |=> !lock_ok);

endmodule

bind pump_phase_comparator pfd_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_sel      (mode_sel),
    .pump_up       (pump_up),
    .pump_dn       (pump_dn),
    .pump_drive_en (pump_drive_en),
    .lock_ok       (lock_ok),
    .ref_tick      (ref_tick),
    .fb_tick       (fb_tick)
);

// File: tb/sim_pump_phase_comparator.sv
`timescale 1ns/1ps
module sim_pump_phase_comparator;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fb_in = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       pump_up, pump_dn, pump_drive_en, lock_ok;

    int n_checks = 0;
    int n_fail   = 0;
    int edges    = 0;
    // bench lock model
    int good_run = 0;
    bit prev_up_bad = 1'b0;
    bit lock_exp = 1'b0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) edges <= 0;
        else        edges <= edges + 1;
    end

    pump_phase_comparator u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .fb_in         (fb_in),
        .mode_sel      (mode_sel),
        .pump_up       (pump_up),
        .pump_dn       (pump_dn),
        .pump_drive_en (pump_drive_en),
        .lock_ok       (lock_ok)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (edge %0d)", tag, act, exp, edges);
        end
    endtask

    task automatic wait_edge(input int e);
        while (edges < e) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        fb_in = 1'b0;
        mode_sel = 2'b00;
        repeat (3) @(negedge clk);
        #1;
        check_eq("R2 reset up", pump_up, 0);
        check_eq("R2 reset dn", pump_dn, 0);
        check_eq("R2 reset en", pump_drive_en, 1);
        check_eq("R2 reset lock", lock_ok, 0);
        @(negedge clk);
        rst_n = 1'b1;
        good_run = 0;
        prev_up_bad = 1'b0;
        lock_exp = 1'b0;
    endtask

    // Reference timing, override modes and clean restart (R1 R6 R7 R8 R9)
    task automatic t_modes_and_restart();
        do_reset();
        wait_edge(75); #1;
        check_eq("R1 up before first ref", pump_up, 0);
        wait_edge(76); #1;
        check_eq("R1 up after first ref", pump_up, 1);
        check_eq("R3 dn while ref leads", pump_dn, 0);
        wait_edge(80); mode_sel = 2'b11; #1;
        check_eq("R8 release en", pump_drive_en, 0);
        check_eq("R8 release up", pump_up, 0);
        check_eq("R8 release dn", pump_dn, 0);
        wait_edge(81); mode_sel = 2'b10; #1;
        check_eq("R6 force low dn", pump_dn, 1);
        check_eq("R6 force low up", pump_up, 0);
        check_eq("R6 force low en", pump_drive_en, 1);
        wait_edge(82); mode_sel = 2'b01; #1;
        check_eq("R7 force high up", pump_up, 1);
        check_eq("R7 force high dn", pump_dn, 0);
        check_eq("R7 force high en", pump_drive_en, 1);
        wait_edge(83); mode_sel = 2'b00; #1;
        check_eq("R9 up after return", pump_up, 0);
        check_eq("R9 dn after return", pump_dn, 0);
        check_eq("R2 track en", pump_drive_en, 1);
        wait_edge(151); #1;
        check_eq("R9 up stays clear", pump_up, 0);
        wait_edge(152); #1;
        check_eq("R1 up after second ref", pump_up, 1);
    endtask

    // One reference period k. d > 0: reference leads by d; d < 0: feedback
    // leads by -d; d = 0: coincident. fmode applied on [A+flo, A+fhi).
    task automatic run_period(input int k, input int d, input logic [1:0] fmode,
                              input int flo, input int fhi);
        int a;
        int exp_up, exp_dn, upc, dnc;
        bit bad;
        a = 76 * (k + 1);
        exp_up = (d > 0) ? d : 0;
        exp_dn = (d < 0) ? -d : 0;
        upc = 0;
        dnc = 0;
        for (int e = a - 35; e <= a + 40; e++) begin
            wait_edge(e);
            fb_in = (e >= a + d - 3) && (e < a + d + 27);
            mode_sel = (fmode != 2'b00 && e >= a + flo && e < a + fhi) ? fmode : 2'b00;
            #1;
            if (mode_sel == 2'b00) begin
                upc += int'(pump_up);
                dnc += int'(pump_dn);
            end
            if (e == a - 1) begin
                check_eq(lock_exp ? "R10 lock before period end" : "R11 lock before period end",
                         lock_ok, int'(lock_exp));
            end
            if (e == a) begin
                bad = prev_up_bad || (exp_dn >= 4);
                good_run = bad ? 0 : good_run + 1;
                lock_exp = (good_run >= 16);
                prev_up_bad = (exp_up >= 4);
                check_eq(lock_exp ? "R10 lock at period end" : "R11 lock at period end",
                         lock_ok, int'(lock_exp));
            end
            if (fmode == 2'b01 && e == a + flo) begin
                check_eq("R7 override up", pump_up, 1);
                check_eq("R7 override dn", pump_dn, 0);
            end
            if (fmode != 2'b00 && e == a + fhi - 1) begin
                check_eq("R12 lock cleared in override", lock_ok, 0);
            end
        end
        if (fmode != 2'b00) begin
            good_run = 0;
            prev_up_bad = 1'b0;
            lock_exp = 1'b0;
        end
        if (d > 0) begin
            check_eq("R3 up run length", upc, exp_up);
            check_eq("R3 no dn when ref leads", dnc, 0);
        end else if (d < 0) begin
            check_eq("R4 dn run length", dnc, exp_dn);
            check_eq("R4 no up when fb leads", upc, 0);
        end else begin
            check_eq("R5 coincident up", upc, 0);
            check_eq("R5 coincident dn", dnc, 0);
        end
    endtask

    // Tracking, dead zone, lock acquire / lose / restart (R3 R4 R5 R10 R11 R12)
    task automatic t_track_and_lock();
        int pat[7] = '{2, -2, 0, 3, -3, 1, -1};
        int k;
        do_reset();
        k = 0;
        for (int i = 0; i < 18; i++) begin
            run_period(k, pat[i % 7], 2'b00, 0, 0);
            k++;
        end
        run_period(k, 6, 2'b00, 0, 0);  k++;   // bad up run, judged next period
        run_period(k, 2, 2'b00, 0, 0);  k++;
        run_period(k, -5, 2'b00, 0, 0); k++;   // bad dn run
        run_period(k, 4, 2'b00, 0, 0);  k++;   // exactly at the limit
        run_period(k, -4, 2'b00, 0, 0); k++;
        for (int i = 0; i < 18; i++) begin
            run_period(k, 1, 2'b00, 0, 0);
            k++;
        end
        run_period(k, 2, 2'b01, 30, 38); k++;   // override while locked
        for (int i = 0; i < 17; i++) begin
            run_period(k, -1, 2'b00, 0, 0);
            k++;
        end
    endtask

    initial begin
        t_modes_and_restart();
        t_track_and_lock();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d (edges)", edges, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule